// File: doc/BRIEF.md
# Stop-Mode Clock Gating Controller

This block owns the deepest low-power state of a microcontroller clock generator. Software requests the state by writing the "halt everything" control bit. The block then turns off the oscillator enable, the CPU clock enable and the peripheral clock enable. In the same edge it forces the system-clock divider to its divide-by-8 code and sets the main oscillator drive strength to high. While the block is stopped, the oscillator output pin is either held high or left as an input, depending on how the oscillator pins are configured.

The block leaves stop on a hardware reset or on a peripheral wake request. Each wake request is asynchronous. It first passes through a two-flop synchronizer on the always-on clock. It is then qualified by three things: the source's 3-bit priority, the source's usability flag (the external clock is selected, or the filter is off), and the global interrupt enable. One source slot, the key input by default, is always usable. The divider keeps its divide-by-8 code after wake-up, so the CPU restarts at one eighth of its earlier clock. A stop request made while oscillation-stop detection is still enabled is refused and flagged.

Top module: `stop_clk_ctrl`

## Requirements
- R1: A one-cycle `stopWr` pulse with `oscDetEn`=0 sets `stopActive` at that rising edge. While `stopActive` is 1, `cpuClkEn`, `perClkEn` and `oscEn` are 0; otherwise they are 1.
- R2: On the entry edge, `divSel` becomes `DIV8_CODE` (default 3) and `oscDrvHigh` becomes 1.
- R3: A `stopWr` pulse with `oscDetEn`=1 leaves `stopActive` at 0 and raises `stopErr` for exactly one cycle after that edge.
- R4: While stopped, a request on source i wakes the block if three conditions hold: the source's priority field `wakePrio[3i+2:3i]` is nonzero, `wakeUsable[i]` is 1, and `globalIe` is 1. A request that rises before edge 1 clears `stopActive` at the third rising edge; it is still 1 after the second. `wakeEvent` is high for the one cycle after the wake edge.
- R5: A source whose priority field is 000b, or any request made while `globalIe` is 0, does not wake the block.
- R6: A source with `wakeUsable[i]`=0 is ignored, unless bit i of `ALWAYS_OK` is set (default: bit 0 only). Such a source wakes the block without the usable flag.
- R7: After an interrupt wake, `divSel` stays at `DIV8_CODE` and `oscDrvHigh` stays at 1 until software writes them.
- R8: `divWr`/`drvWr` writes take effect at the next edge while the block is running. They are ignored while it is stopped.
- R9: While stopped, `xoutForceHigh` equals `oscPinMode` and `xoutForceInput` equals its inverse. Outside stop, both outputs are 0.
- R10: Reset (`rstN`=0), even in stop, clears `stopActive`, sets `divSel` to `DIV_RST` (default 0) and sets `oscDrvHigh` to `DRV_RST` (default 0).
- R11: Wake requests that arrive while the block is running produce no `wakeEvent` and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running always-on clock |
| rstN | input | 1 | Hardware reset, active low, asynchronous |
| stopWr | input | 1 | Strobe: software wrote 1 to the halt-all-clocks bit |
| oscDetEn | input | 1 | Oscillation-stop detection enabled |
| divWr | input | 1 | Divider select write strobe |
| divIn | input | DIV_W | Divider select write data |
| drvWr | input | 1 | Drive strength write strobe |
| drvIn | input | 1 | Drive strength write data |
| oscPinMode | input | 1 | 1: oscillator pins in oscillator mode, 0: ports |
| wakeReq | input | NSRC | Asynchronous wake requests |
| wakePrio | input | NSRC*PRIO_W | Priority level per source, 0 = disabled |
| wakeUsable | input | NSRC | Per-source wake usability condition met |
| globalIe | input | 1 | Global interrupt enable |
| cpuClkEn | output | 1 | CPU clock enable |
| perClkEn | output | 1 | Peripheral clock enable |
| oscEn | output | 1 | Oscillator enable |
| divSel | output | DIV_W | System clock divider select |
| oscDrvHigh | output | 1 | Main oscillator drive strength high |
| xoutForceHigh | output | 1 | Hold oscillator output pin high |
| xoutForceInput | output | 1 | Hold oscillator output pin as input |
| stopActive | output | 1 | Stop state |
| stopErr | output | 1 | One-cycle flag: stop refused, detection enabled |
| wakeEvent | output | 1 | One-cycle pulse on interrupt wake-up |

## Verification
The bench uses the defaults: six sources, 3-bit priorities, a 2-bit divider with code 3 for divide-by-8, and only slot 0 always usable. These values let the stimulus table reach the lowest slot, which is always usable, and the highest slot index 5. They also cover the extreme priorities 000b and 111b. Between them, the vectors exercise every way a wake can be blocked: priority, global enable and usability. A reset default of 0 for both divider and drive means a forced value can never be mistaken for a reset value.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;
  typedef struct packed {
    logic enterStop;
    logic cfgLock;
  } stopStrobe_t;
endpackage

// File: rtl/stopctl_ctrl.sv
module stopctl_ctrl
  import stopctl_pkg::*;
#(
  parameter int NSRC = 6,
  parameter int PRIO_W = 3,
  parameter logic [NSRC-1:0] ALWAYS_OK = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   stopWr,
  input  logic                   oscDetEn,
  input  logic [NSRC-1:0]        wakeReq,
  input  logic [NSRC*PRIO_W-1:0] wakePrio,
  input  logic [NSRC-1:0]        wakeUsable,
  input  logic                   globalIe,
  output logic                   stopActive,
  output logic                   stopErr,
  output logic                   wakeEvent,
  output stopStrobe_t            stb
);
  logic [NSRC-1:0] syncA, syncB, srcHit;
  logic wakeNow, enterNow;

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_qual
      assign srcHit[gi] = syncB[gi] & (|wakePrio[gi*PRIO_W +: PRIO_W])
                        & (wakeUsable[gi] | ALWAYS_OK[gi]);
    end
  endgenerate

  assign wakeNow  = stopActive & globalIe & (|srcHit);
  assign enterNow = stopWr & ~oscDetEn & ~stopActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA      <= '0;
      syncB      <= '0;
      stopActive <= 1'b0;
      stopErr    <= 1'b0;
      wakeEvent  <= 1'b0;
    end else begin
      syncA     <= wakeReq;
      syncB     <= syncA;
      stopErr   <= stopWr & oscDetEn & ~stopActive;
      wakeEvent <= wakeNow;
      if (wakeNow)       stopActive <= 1'b0;
      else if (enterNow) stopActive <= 1'b1;
    end
  end

  assign stb.enterStop = enterNow;
  assign stb.cfgLock   = stopActive;

  // R3: refused request never enters stop and is flagged
  a_r3_err_blocks_entry: assert property (@(posedge clk) disable iff (!rstN)
    (stopWr && oscDetEn && !stopActive) |=> (!stopActive && stopErr));
  // R5: a wake needs the global enable
  a_r5_wake_needs_ie: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stopActive) |-> $past(globalIe));
  // R4: leaving stop by interrupt is announced
  a_r4_wake_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stopActive) |-> wakeEvent);
endmodule

// File: rtl/stopctl_dpath.sv
module stopctl_dpath
  import stopctl_pkg::*;
#(
  parameter int DIV_W = 2,
  parameter logic [DIV_W-1:0] DIV8_CODE = 3,
  parameter logic [DIV_W-1:0] DIV_RST = 0,
  parameter logic DRV_RST = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             divWr,
  input  logic [DIV_W-1:0] divIn,
  input  logic             drvWr,
  input  logic             drvIn,
  input  stopStrobe_t      stb,
  output logic [DIV_W-1:0] divSel,
  output logic             oscDrvHigh
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divSel     <= DIV_RST;
      oscDrvHigh <= DRV_RST;
    end else if (stb.enterStop) begin
      divSel     <= DIV8_CODE;
      oscDrvHigh <= 1'b1;
    end else if (!stb.cfgLock) begin
      if (divWr) divSel     <= divIn;
      if (drvWr) oscDrvHigh <= drvIn;
    end
  end

  // R2: entry forces divide-by-8 and high drive
  a_r2_forced_on_entry: assert property (@(posedge clk) disable iff (!rstN)
    stb.enterStop |=> (divSel == DIV8_CODE && oscDrvHigh));
  // R8: configuration frozen while stopped
  a_r8_locked_in_stop: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cfgLock && $past(stb.cfgLock)) |-> ($stable(divSel) && $stable(oscDrvHigh)));
endmodule

// File: rtl/stop_clk_ctrl.sv
module stop_clk_ctrl
  import stopctl_pkg::*;
#(
  parameter int NSRC = 6,
  parameter int PRIO_W = 3,
  parameter int DIV_W = 2,
  parameter logic [DIV_W-1:0] DIV8_CODE = 3,
  parameter logic [DIV_W-1:0] DIV_RST = 0,
  parameter logic DRV_RST = 1'b0,
  parameter logic [NSRC-1:0] ALWAYS_OK = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   stopWr,
  input  logic                   oscDetEn,
  input  logic                   divWr,
  input  logic [DIV_W-1:0]       divIn,
  input  logic                   drvWr,
  input  logic                   drvIn,
  input  logic                   oscPinMode,
  input  logic [NSRC-1:0]        wakeReq,
  input  logic [NSRC*PRIO_W-1:0] wakePrio,
  input  logic [NSRC-1:0]        wakeUsable,
  input  logic                   globalIe,
  output logic                   cpuClkEn,
  output logic                   perClkEn,
  output logic                   oscEn,
  output logic [DIV_W-1:0]       divSel,
  output logic                   oscDrvHigh,
  output logic                   xoutForceHigh,
  output logic                   xoutForceInput,
  output logic                   stopActive,
  output logic                   stopErr,
  output logic                   wakeEvent
);
  stopStrobe_t stb;

  stopctl_ctrl #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ALWAYS_OK(ALWAYS_OK)) u_ctrl (
    .clk(clk), .rstN(rstN), .stopWr(stopWr), .oscDetEn(oscDetEn),
    .wakeReq(wakeReq), .wakePrio(wakePrio), .wakeUsable(wakeUsable),
    .globalIe(globalIe), .stopActive(stopActive), .stopErr(stopErr),
    .wakeEvent(wakeEvent), .stb(stb));

  stopctl_dpath #(.DIV_W(DIV_W), .DIV8_CODE(DIV8_CODE), .DIV_RST(DIV_RST),
                  .DRV_RST(DRV_RST)) u_dpath (
    .clk(clk), .rstN(rstN), .divWr(divWr), .divIn(divIn), .drvWr(drvWr),
    .drvIn(drvIn), .stb(stb), .divSel(divSel), .oscDrvHigh(oscDrvHigh));

  assign cpuClkEn       = ~stopActive;
  assign perClkEn       = ~stopActive;
  assign oscEn          = ~stopActive;
  assign xoutForceHigh  = stopActive & oscPinMode;
  assign xoutForceInput = stopActive & ~oscPinMode;

  // R9: pin is never both driven high and held as input
  a_r9_pin_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({xoutForceHigh, xoutForceInput}));
  // R1: enable outputs drop together
  a_r1_enables_agree: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn == perClkEn) && (perClkEn == oscEn));
endmodule

// File: tb/sim_stop_clk_ctrl.sv
module sim_stop_clk_ctrl;
  localparam int NSRC = 6;
  localparam int PRIO_W = 3;
  localparam int DIV_W = 2;

  logic clk = 0, rstN = 0;
  logic stopWr = 0, oscDetEn = 0, divWr = 0, drvWr = 0, drvIn = 0;
  logic oscPinMode = 1, globalIe = 0;
  logic [DIV_W-1:0] divIn = '0;
  logic [NSRC-1:0] wakeReq = '0, wakeUsable = '0;
  logic [NSRC*PRIO_W-1:0] wakePrio = '0;
  logic cpuClkEn, perClkEn, oscEn, oscDrvHigh, xoutForceHigh, xoutForceInput;
  logic stopActive, stopErr, wakeEvent;
  logic [DIV_W-1:0] divSel;
  int nRun = 0, nFail = 0;

  always #10 clk = ~clk;

  stop_clk_ctrl u0 (
    .clk(clk), .rstN(rstN), .stopWr(stopWr), .oscDetEn(oscDetEn),
    .divWr(divWr), .divIn(divIn), .drvWr(drvWr), .drvIn(drvIn),
    .oscPinMode(oscPinMode), .wakeReq(wakeReq), .wakePrio(wakePrio),
    .wakeUsable(wakeUsable), .globalIe(globalIe), .cpuClkEn(cpuClkEn),
    .perClkEn(perClkEn), .oscEn(oscEn), .divSel(divSel),
    .oscDrvHigh(oscDrvHigh), .xoutForceHigh(xoutForceHigh),
    .xoutForceInput(xoutForceInput), .stopActive(stopActive),
    .stopErr(stopErr), .wakeEvent(wakeEvent));

  // vector: {src[2:0], prio[2:0], ie, usable, expWake}
  localparam logic [8:0] VEC [8] = '{
    {3'd1, 3'd3, 1'b1, 1'b1, 1'b1},   // R4 plain wake
    {3'd1, 3'd0, 1'b1, 1'b1, 1'b0},   // R5 priority zero
    {3'd2, 3'd5, 1'b0, 1'b1, 1'b0},   // R5 global enable off
    {3'd3, 3'd2, 1'b1, 1'b0, 1'b0},   // R6 not usable
    {3'd0, 3'd1, 1'b1, 1'b0, 1'b1},   // R6 always-usable slot
    {3'd5, 3'd7, 1'b1, 1'b1, 1'b1},   // R4 top slot
    {3'd4, 3'd4, 1'b1, 1'b0, 1'b0},   // R6 not usable
    {3'd0, 3'd0, 1'b1, 1'b1, 1'b0}    // R5 key slot priority zero
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 0;
    @(negedge clk);
    @(negedge clk) rstN = 1;
  endtask

  task automatic enterStop();
    @(negedge clk) stopWr = 1;
    @(negedge clk) stopWr = 0;
  endtask

  task automatic wakeUp();
    @(negedge clk) begin
      wakePrio = '0; wakePrio[2:0] = 3'd1; globalIe = 1; wakeReq[0] = 1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) wakeReq = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    doReset();
    // R10 reset state
    check("R10 stop after reset", stopActive, 0);
    check("R10 div after reset", divSel, 0);
    check("R10 drv after reset", oscDrvHigh, 0);
    check("R1 cpu clock on", cpuClkEn, 1);
    check("R3 no err", stopErr, 0);
    check("R9 pins free", {xoutForceHigh, xoutForceInput}, 0);

    for (int v = 0; v < 8; v++) begin
      int src;
      src = int'(VEC[v][8:6]);
      doReset();
      @(negedge clk) begin
        wakePrio = '0;
        wakePrio[src*PRIO_W +: PRIO_W] = VEC[v][5:3];
        globalIe = VEC[v][2];
        wakeUsable = '0;
        wakeUsable[src] = VEC[v][1];
      end
      enterStop();
      check($sformatf("R1 stop v%0d", v), stopActive, 1);
      check($sformatf("R1 enables off v%0d", v), {cpuClkEn, perClkEn, oscEn}, 0);
      check($sformatf("R2 div8 v%0d", v), {divSel, oscDrvHigh}, {2'd3, 1'b1});
      @(negedge clk) wakeReq[src] = 1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check($sformatf("R4 still stopped v%0d", v), stopActive, 1);
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R4 R5 R6 stop v%0d", v), stopActive, !VEC[v][0]);
      check($sformatf("R4 wakeEvent v%0d", v), wakeEvent, VEC[v][0]);
      wakeReq = '0;
      @(negedge clk);
      check($sformatf("R4 pulse width v%0d", v), wakeEvent, 0);
    end

    // R3 refused stop
    doReset();
    @(negedge clk) begin oscDetEn = 1; stopWr = 1; end
    @(negedge clk) begin stopWr = 0; oscDetEn = 0; end
    check("R3 err flagged", stopErr, 1);
    check("R3 not stopped", stopActive, 0);
    check("R3 div untouched", divSel, 0);
    @(negedge clk);
    check("R3 err one cycle", stopErr, 0);

    // R8 writes while running and while stopped
    @(negedge clk) begin divWr = 1; divIn = 2'd1; drvWr = 1; drvIn = 0; end
    @(negedge clk) begin divWr = 0; drvWr = 0; end
    check("R8 run write div", divSel, 1);
    enterStop();
    check("R2 forced from 1", divSel, 3);
    @(negedge clk) begin divWr = 1; divIn = 2'd2; drvWr = 1; drvIn = 0; end
    @(negedge clk) begin divWr = 0; drvWr = 0; end
    check("R8 stopped div ignored", divSel, 3);
    check("R8 stopped drv ignored", oscDrvHigh, 1);

    // R9 pin states in stop
    @(negedge clk) oscPinMode = 1;
    #1 check("R9 osc mode high", {xoutForceHigh, xoutForceInput}, 2'b10);
    @(negedge clk) oscPinMode = 0;
    #1 check("R9 port mode input", {xoutForceHigh, xoutForceInput}, 2'b01);

    // R7 after wake the forced values persist until written
    wakeUp();
    check("R7 awake", stopActive, 0);
    check("R7 div kept", divSel, 3);
    check("R7 drv kept", oscDrvHigh, 1);
    check("R9 pins free after wake", {xoutForceHigh, xoutForceInput}, 0);
    @(negedge clk) begin divWr = 1; divIn = 2'd0; end
    @(negedge clk) divWr = 0;
    check("R7 div writable after wake", divSel, 0);

    // R11 wake requests while running
    @(negedge clk) begin
      wakePrio = '0; wakePrio[5:3] = 3'd6; wakeUsable = '1; globalIe = 1; wakeReq[1] = 1;
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R11 no wakeEvent", wakeEvent, 0);
    end
    check("R11 still running", stopActive, 0);
    @(negedge clk) wakeReq = '0;

    // R10 reset during stop
    @(negedge clk) begin globalIe = 0; end
    enterStop();
    check("R10 in stop", stopActive, 1);
    doReset();
    check("R10 stop cleared", stopActive, 0);
    check("R10 div default", divSel, 0);
    check("R10 drv default", oscDrvHigh, 0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule